// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the device end of a three-wire serial non-volatile memory that holds 256 words of 16 bits. A host drives chip select, a serial clock and a data line. The block answers on a data-out pin and a separate output-enable, so the pin can be tri-stated at the pad. All three host inputs are brought into the fast system clock domain through two-stage synchronizers, and serial-clock rising edges are detected there.

A transaction starts with a 1 start bit. Any zeros clocked in before it are skipped. A 2-bit opcode follows, then 8 address bits, and for the two programming commands that carry data, 16 data bits. The block supports:
- reading one word,
- programming one word,
- erasing one word,
- filling the whole array with one value,
- wiping the whole array,
- setting and clearing a write-enable latch.

Programming is started by the falling edge of chip select. It then runs for a programmable number of system clock cycles, standing in for the self-timed cycle of a real cell array. While that cycle runs, the host can raise chip select and poll busy/ready on the data-out pin.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output-enable is low, the write-enable latch is clear and every word reads 16'hFFFF.
- R2: Zeros sampled before the start bit are skipped. After a start bit of 1, the block takes a 2-bit opcode and then 8 address bits, all MSB first, each sampled on a rising edge of the serial clock while chip select is high.
- R3: Opcode 2'b10 reads a word, whatever the state of the write-enable latch. After the last address edge, data-out is enabled and drives a 0. Each of the next 16 rising edges then shifts out one data bit, MSB first. The 17th rising edge releases the output.
- R4: Opcode 2'b00 with address bits [7:6] = 2'b11 sets the write-enable latch, and with [7:6] = 2'b00 clears it. The other six address bits are don't care. While the latch is clear, the single-word write, single-word erase, fill and wipe commands leave the array unchanged.
- R5: Opcode 2'b01 takes 16 data bits after the address. On the next falling edge of chip select, it replaces the addressed word with those bits.
- R6: Opcode 2'b11 sets the addressed word to 16'hFFFF on the falling edge of chip select after the last address bit. Other words are left alone.
- R7: Opcode 2'b00 with [7:6] = 2'b01, followed by 16 data bits, writes that value into every word. With [7:6] = 2'b10 it sets every word to 16'hFFFF. Both act on the falling edge of chip select.
- R8: A program cycle lasts PROG_CYCLES system clocks from the chip-select fall that starts it. If chip select is high during that cycle, the output is enabled and drives 0. Once the cycle ends, it drives 1, until chip select falls. The output-enable is low whenever chip select has been low for three clocks.
- R9: After chip select is raised during a program cycle, all serial activity is ignored until chip select falls again.
- R10: Lowering chip select before the last bit of a command aborts the command with no effect. A programming command is also dropped if another rising edge arrives after its last bit, before chip select falls.
- R11: With WORDS = 128, address bit A7 is don't care, so addresses 8'h85 and 8'h05 select the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip select from the host, asynchronous |
| skIn | input | 1 | Serial clock from the host, asynchronous |
| diIn | input | 1 | Serial data from the host, asynchronous |
| doOut | output | 1 | Serial data or busy/ready status to the host |
| doOe | output | 1 | Output enable for the data-out pad; low means high impedance |

## Verification
The assertions assume that every host input holds each level for several system clocks. They also assume that data-in is stable around each serial-clock rising edge, and that chip select stays low for more than three clocks between transactions. The stimulus keeps to these rules: each serial-clock half period lasts eight system clocks, data-in changes only while the serial clock is low, and chip select is changed only on falling system-clock edges, with gaps of at least eight clocks. A second instance built with 128 words receives the same pins, so address aliasing is checked under identical traffic.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } opcode_e;

  // sub-command selected by the two top address bits under OP_EXT
  typedef enum logic [1:0] {
    SUB_LOCK   = 2'b00,
    SUB_FILL   = 2'b01,
    SUB_WIPE   = 2'b10,
    SUB_UNLOCK = 2'b11
  } subcmd_e;

  typedef enum logic [2:0] {
    PG_NONE,
    PG_WORD,
    PG_CLEAR_WORD,
    PG_FILL,
    PG_WIPE
  } prog_e;

  typedef struct packed {
    logic  capture;   // shift diBit into the frame register
    logic  loadRead;  // fetch addressed word, present dummy zero
    logic  shiftOut;  // present next read bit
    prog_e prog;      // one-cycle program request
  } dp_strobe_t;

endpackage

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_BITS   = 8,
  parameter int PROG_CYCLES = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csIn,
  input  logic       skIn,
  input  logic       diIn,
  input  logic [1:0] cmdField,
  output dp_strobe_t strobe,
  output logic       diBit,
  output logic       busy,
  output logic       wenLatch,
  output logic       showStatus,
  output logic       statusBit,
  output logic       doOe
);

  localparam int CNT_W  = $clog2(DATA_W + 2);
  localparam int BUSY_W = $clog2(PROG_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_OPCODE, S_ADDR, S_DECODE, S_DATA,
    S_ARMED, S_READ, S_STATUS, S_DISCARD
  } state_e;

  logic [SYNC_STAGES-1:0] csSync, skSync, diSync;
  logic skPrev;
  logic csS, skS, diS, skRise;

  state_e             state;
  logic [CNT_W-1:0]   bitCnt;
  opcode_e            opReg;
  prog_e              pendKind;
  logic [BUSY_W-1:0]  busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csSync <= '0;
      skSync <= '0;
      diSync <= '0;
      skPrev <= 1'b0;
    end else begin
      csSync <= {csSync[SYNC_STAGES-2:0], csIn};
      skSync <= {skSync[SYNC_STAGES-2:0], skIn};
      diSync <= {diSync[SYNC_STAGES-2:0], diIn};
      skPrev <= skSync[SYNC_STAGES-1];
    end
  end

  assign csS    = csSync[SYNC_STAGES-1];
  assign skS    = skSync[SYNC_STAGES-1];
  assign diS    = diSync[SYNC_STAGES-1];
  assign skRise = skS & ~skPrev;
  assign diBit  = diS;

  assign busy       = (busyCnt != '0);
  assign showStatus = (state == S_STATUS);
  assign doOe       = (state == S_READ) || (state == S_STATUS);

  always_comb begin
    strobe          = '0;
    strobe.prog     = PG_NONE;
    strobe.capture  = csS && skRise && ((state == S_ADDR) || (state == S_DATA));
    strobe.loadRead = csS && (state == S_DECODE) && (opReg == OP_READ);
    strobe.shiftOut = csS && skRise && (state == S_READ) && (bitCnt != CNT_W'(DATA_W));
    if ((state == S_ARMED) && !csS) strobe.prog = pendKind;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      opReg     <= OP_EXT;
      pendKind  <= PG_NONE;
      busyCnt   <= '0;
      wenLatch  <= 1'b0;
      statusBit <= 1'b0;
    end else begin
      statusBit <= ~busy;

      if (strobe.prog != PG_NONE) busyCnt <= BUSY_W'(PROG_CYCLES);
      else if (busy)              busyCnt <= busyCnt - 1'b1;

      if (!csS) begin
        state  <= S_IDLE;
        bitCnt <= '0;
      end else begin
        case (state)
          S_IDLE: begin
            if (busy) state <= S_STATUS;
            else if (skRise && diS) begin
              state  <= S_OPCODE;
              bitCnt <= '0;
            end
          end
          S_OPCODE: if (skRise) begin
            opReg <= opcode_e'({opReg[0], diS});
            if (bitCnt == CNT_W'(1)) begin
              state  <= S_ADDR;
              bitCnt <= '0;
            end else bitCnt <= bitCnt + 1'b1;
          end
          S_ADDR: if (skRise) begin
            if (bitCnt == CNT_W'(ADDR_BITS - 1)) begin
              state  <= S_DECODE;
              bitCnt <= '0;
            end else bitCnt <= bitCnt + 1'b1;
          end
          S_DECODE: begin
            case (opReg)
              OP_READ:  state <= S_READ;
              OP_WRITE: begin
                pendKind <= PG_WORD;
                state    <= S_DATA;
              end
              OP_ERASE: begin
                pendKind <= PG_CLEAR_WORD;
                state    <= wenLatch ? S_ARMED : S_DISCARD;
              end
              default: begin
                case (subcmd_e'(cmdField))
                  SUB_UNLOCK: begin
                    wenLatch <= 1'b1;
                    state    <= S_DISCARD;
                  end
                  SUB_LOCK: begin
                    wenLatch <= 1'b0;
                    state    <= S_DISCARD;
                  end
                  SUB_FILL: begin
                    pendKind <= PG_FILL;
                    state    <= S_DATA;
                  end
                  default: begin
                    pendKind <= PG_WIPE;
                    state    <= wenLatch ? S_ARMED : S_DISCARD;
                  end
                endcase
              end
            endcase
          end
          S_DATA: if (skRise) begin
            if (bitCnt == CNT_W'(DATA_W - 1)) begin
              state  <= wenLatch ? S_ARMED : S_DISCARD;
              bitCnt <= '0;
            end else bitCnt <= bitCnt + 1'b1;
          end
          S_ARMED: if (skRise) state <= S_DISCARD;
          S_READ: if (skRise) begin
            if (bitCnt == CNT_W'(DATA_W)) state <= S_DISCARD;
            else bitCnt <= bitCnt + 1'b1;
          end
          S_STATUS, S_DISCARD: state <= state;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mw_eeprom_datapath.sv
module mw_eeprom_datapath
  import mw_eeprom_pkg::*;
#(
  parameter int WORDS     = 256,
  parameter int DATA_W    = 16,
  parameter int ADDR_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_strobe_t strobe,
  input  logic       diBit,
  output logic [1:0] cmdField,
  output logic       readBit
);

  localparam int IDX_W   = $clog2(WORDS);
  localparam int FRAME_W = ADDR_BITS + DATA_W;

  logic [DATA_W-1:0]  mem [WORDS];
  logic [FRAME_W-1:0] frameReg;
  logic [DATA_W-1:0]  outReg;
  logic [IDX_W-1:0]   shortIdx;
  logic [IDX_W-1:0]   longIdx;

  // address sits at the bottom after an address-only frame,
  // and above the data after a frame that carries data
  assign shortIdx = frameReg[IDX_W-1:0];
  assign longIdx  = frameReg[DATA_W +: IDX_W];
  assign cmdField = frameReg[ADDR_BITS-1 -: 2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      frameReg <= '0;
      outReg   <= '0;
      readBit  <= 1'b0;
    end else begin
      if (strobe.capture) frameReg <= {frameReg[FRAME_W-2:0], diBit};

      if (strobe.loadRead) begin
        outReg  <= mem[shortIdx];
        readBit <= 1'b0;
      end else if (strobe.shiftOut) begin
        readBit <= outReg[DATA_W-1];
        outReg  <= {outReg[DATA_W-2:0], 1'b0};
      end

      case (strobe.prog)
        PG_WORD:       mem[longIdx]  <= frameReg[DATA_W-1:0];
        PG_CLEAR_WORD: mem[shortIdx] <= '1;
        PG_FILL:       for (int i = 0; i < WORDS; i++) mem[i] <= frameReg[DATA_W-1:0];
        PG_WIPE:       for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        default:       ;
      endcase
    end
  end

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_eeprom_pkg::*;
#(
  parameter int WORDS       = 256,
  parameter int DATA_W      = 16,
  parameter int ADDR_BITS   = 8,
  parameter int PROG_CYCLES = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut,
  output logic doOe
);

  dp_strobe_t ctlStrobe;
  logic       diBit;
  logic [1:0] cmdField;
  logic       readBit;
  logic       busy;
  logic       wenLatch;
  logic       showStatus;
  logic       statusBit;

  mw_eeprom_ctrl #(
    .DATA_W(DATA_W), .ADDR_BITS(ADDR_BITS),
    .PROG_CYCLES(PROG_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .cmdField(cmdField), .strobe(ctlStrobe), .diBit(diBit),
    .busy(busy), .wenLatch(wenLatch), .showStatus(showStatus),
    .statusBit(statusBit), .doOe(doOe)
  );

  mw_eeprom_datapath #(
    .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_BITS(ADDR_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(ctlStrobe), .diBit(diBit),
    .cmdField(cmdField), .readBit(readBit)
  );

  assign doOut = showStatus ? statusBit : readBit;

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_eeprom_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       csIn,
  input logic       doOut,
  input logic       doOe,
  input logic       busy,
  input logic       wenLatch,
  input dp_strobe_t strobe
);

  // R8
  oe_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csIn && $past(!csIn) && $past(!csIn, 2) && $past(!csIn, 3)) |-> !doOe);

  // R8
  timer_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.prog != PG_NONE) |=> busy);

  // R4
  enable_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.prog != PG_NONE) |-> wenLatch);

  // R9
  prog_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.prog != PG_NONE) |-> !busy);

  // R9
  capture_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> !busy);

  // R3
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRead |=> (doOe && !doOut));

  // R3
  shift_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftOut |=> doOe);

endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rstN(rstN), .csIn(csIn), .doOut(doOut), .doOe(doOe),
  .busy(busy), .wenLatch(wenLatch), .strobe(ctlStrobe)
);

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SK    = 8;
  localparam int PROG       = 200;
  localparam int NVEC       = 15;

  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic doA, oeA, doB, oeB;

  mw_eeprom #(.WORDS(256), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di), .doOut(doA), .doOe(oeA));
  mw_eeprom #(.WORDS(128), .PROG_CYCLES(PROG)) dut128 (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di), .doOut(doB), .doOe(oeB));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // op: 0 write, 1 erase, 2 fill, 3 wipe, 4 enable, 5 disable
  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [7:0]  rdAddr;
    logic [15:0] expect_;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd4, 3'd0, 8'h10, 16'h1234, 8'h10, 16'hFFFF},  // R4 latch clear at start
    '{4'd4, 3'd4, 8'hC3, 16'h0000, 8'h10, 16'hFFFF},
    '{4'd5, 3'd0, 8'h10, 16'h1234, 8'h10, 16'h1234},  // R5
    '{4'd5, 3'd0, 8'hFF, 16'hA5C3, 8'hFF, 16'hA5C3},
    '{4'd5, 3'd0, 8'h00, 16'h0001, 8'h00, 16'h0001},
    '{4'd6, 3'd1, 8'h10, 16'h0000, 8'h10, 16'hFFFF},  // R6
    '{4'd6, 3'd1, 8'h00, 16'h0000, 8'hFF, 16'hA5C3},
    '{4'd7, 3'd2, 8'h55, 16'h5A5A, 8'h37, 16'h5A5A},  // R7
    '{4'd7, 3'd3, 8'hAA, 16'h0000, 8'hFF, 16'hFFFF},
    '{4'd7, 3'd2, 8'h7E, 16'h0F0F, 8'h00, 16'h0F0F},
    '{4'd4, 3'd5, 8'h3C, 16'h0000, 8'h00, 16'h0F0F},
    '{4'd4, 3'd3, 8'h99, 16'h0000, 8'h80, 16'h0F0F},  // R4 wipe refused
    '{4'd4, 3'd0, 8'h80, 16'h0000, 8'h80, 16'h0F0F},  // R3 read while disabled
    '{4'd4, 3'd4, 8'hFF, 16'h0000, 8'h80, 16'h0F0F},
    '{4'd5, 3'd0, 8'h80, 16'hC0DE, 8'h80, 16'hC0DE}
  };

  function automatic string reqName(input logic [3:0] n);
    case (n)
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    di = b;
    ticks(HALF_SK);
    sk = 1'b1;
    ticks(HALF_SK);
    sk = 1'b0;
  endtask

  task automatic sendBits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic frameHead(input logic [1:0] op, input logic [7:0] addr);
    cs = 1'b1;
    ticks(2);
    pulse(1'b1);
    sendBits({14'd0, op}, 2);
    sendBits({8'd0, addr}, 8);
  endtask

  task automatic dropCs();
    cs = 1'b0;
    di = 1'b0;
    ticks(HALF_SK);
  endtask

  task automatic readWord(input logic [7:0] addr, output logic [15:0] wA, output logic [15:0] wB);
    frameHead(2'b10, addr);
    check("R3 dummy", {30'd0, oeA, doA}, 32'h2);
    wA = '0;
    wB = '0;
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0);
      wA = {wA[14:0], doA};
      wB = {wB[14:0], doB};
    end
    pulse(1'b0);
    check("R3 release", {31'd0, oeA}, 32'h0);
    dropCs();
  endtask

  task automatic issue(input vec_t v);
    case (v.op)
      3'd0: begin frameHead(2'b01, v.addr); sendBits(v.data, 16); end
      3'd1: frameHead(2'b11, v.addr);
      3'd2: begin frameHead(2'b00, v.addr); sendBits(v.data, 16); end
      default: frameHead(2'b00, v.addr);
    endcase
    dropCs();
    ticks(PROG + 40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, all requirements actual=hung expected=done");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] rA, rB;
    ticks(5);
    check("R1 oe in reset", {31'd0, oeA}, 32'h0);
    rstN = 1'b1;
    ticks(5);
    check("R1 oe after reset", {31'd0, oeA}, 32'h0);
    readWord(8'h42, rA, rB);
    check("R1 erased", {16'd0, rA}, 32'hFFFF);

    for (int k = 0; k < NVEC; k++) begin
      issue(VECS[k]);
      readWord(VECS[k].rdAddr, rA, rB);
      check(reqName(VECS[k].req), {16'd0, rA}, {16'd0, VECS[k].expect_});
    end

    // R2: leading zeros before the start bit
    cs = 1'b1;
    ticks(2);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    readWord(8'hFF, rA, rB);
    check("R2 leading zeros", {16'd0, rA}, 32'h0F0F);

    // R8: busy then ready while CS held high; R9: frame during status ignored
    frameHead(2'b01, 8'h21);
    sendBits(16'h1111, 16);
    dropCs();
    cs = 1'b1;
    ticks(HALF_SK);
    check("R8 status oe", {31'd0, oeA}, 32'h1);
    check("R8 busy early", {31'd0, doA}, 32'h0);
    ticks(PROG - 60);
    check("R8 busy late", {31'd0, doA}, 32'h0);
    ticks(60);
    check("R8 ready", {31'd0, doA}, 32'h1);
    pulse(1'b1);
    sendBits(16'h0001, 2);
    sendBits(16'h0020, 8);
    sendBits(16'h2222, 16);
    check("R9 still status", {30'd0, oeA, doA}, 32'h3);
    dropCs();
    ticks(2);
    check("R8 released", {31'd0, oeA}, 32'h0);
    ticks(PROG + 40);
    readWord(8'h20, rA, rB);
    check("R9 ignored frame", {16'd0, rA}, 32'h0F0F);
    readWord(8'h21, rA, rB);
    check("R8 write landed", {16'd0, rA}, 32'h1111);

    // R10: short data and an extra edge both abort
    frameHead(2'b01, 8'h30);
    sendBits(16'h3333, 10);
    dropCs();
    ticks(PROG + 40);
    readWord(8'h30, rA, rB);
    check("R10 short frame", {16'd0, rA}, 32'h0F0F);
    frameHead(2'b01, 8'h31);
    sendBits(16'h4444, 16);
    pulse(1'b0);
    dropCs();
    ticks(PROG + 40);
    readWord(8'h31, rA, rB);
    check("R10 extra edge", {16'd0, rA}, 32'h0F0F);

    // R11: A7 ignored by the 128-word build
    frameHead(2'b01, 8'h85);
    sendBits(16'hBEEF, 16);
    dropCs();
    ticks(PROG + 40);
    readWord(8'h05, rA, rB);
    check("R11 alias 128", {16'd0, rB}, 32'hBEEF);
    check("R11 no alias 256", {16'd0, rA}, 32'h0F0F);

    finished = 1'b1;
    report();
    $finish;
  end

endmodule